// File: doc/BRIEF.md
# Indexed Bus Response Multiplexer

This block carries one slave's reply back to a single master on a shared bus. When the master issues a request, it also presents a one-hot vector that marks the target slave. The block turns that vector into a small binary index and stores it. The stored index then steers a balanced multiplexer. The multiplexer picks the acknowledge, error and read data of that one slave and passes them to the master.

The index stays fixed until the addressed slave answers, so a reply that arrives several cycles later still reaches the master. Replies from any other slave are dropped. The return path is one shallow mux whose depth is set by the index width. It is not a chain of tests over every slave's acknowledge. Two mux builds are offered: a flat indexed table, and an explicit binary tree built level by level.

Top module: `resp_index_mux`

## Requirements
- R1: A cycle with `i_req` high and a nonzero `i_sel` stores the binary number of the selected slave as the index. Bit k of `i_sel` (and of `i_slv_ack`/`i_slv_err`) belongs to slave k. From the next cycle a reply from slave k is routed.
- R2: With no request outstanding, acknowledges and errors from every slave are ignored. A request with `i_sel` all zero stores nothing: the index and the outstanding state stay as they were.
- R3: While a request is outstanding, `o_ack` equals the indexed slave's acknowledge. `o_data` always shows the indexed slave's data word, taken from bits `[k*DATA_W +: DATA_W]` of `i_slv_data`.
- R4: Acknowledges and errors from slaves other than the indexed one never reach `o_ack` or `o_err`, including in the cycle where the indexed slave answers.
- R5: The index and the outstanding state hold through any number of cycles without a reply from the indexed slave.
- R6: A reply from the indexed slave (ack or err) ends the outstanding state. A later ack or err from the same slave is not forwarded until a new request.
- R7: `o_err` follows the indexed slave's error while a request is outstanding, and `o_ack` stays low if that slave raises only its error.
- R8: If `i_sel` has several bits set, the lowest set bit picks the slave. With `STRICT_SEL` = 1, an assertion reports such a select.
- R9: While reset is held, `o_ack` and `o_err` are low. After reset the index is 0, so `o_data` shows slave 0's data.
- R10: A new request that arrives in the same cycle as the reply to the previous one is stored, and the request stays outstanding for the new slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_req | input | 1 | Request strobe from the master |
| i_sel | input | NUM_SLAVES | One-hot target slave of the request |
| i_slv_ack | input | NUM_SLAVES | Acknowledge from each slave |
| i_slv_err | input | NUM_SLAVES | Error from each slave |
| i_slv_data | input | NUM_SLAVES*DATA_W | Read data of all slaves, slave k in slice k |
| o_ack | output | 1 | Forwarded acknowledge |
| o_err | output | 1 | Forwarded error |
| o_data | output | DATA_W | Read data of the indexed slave |

## Verification
The bench builds the block with six slaves, 16-bit data, the binary-tree mux and `STRICT_SEL` = 0. Six is not a power of two, so the tree gets padded leaves and a three-bit index whose top codes are never used; routing through those uneven branches is therefore exercised. Switching off the strict select check lets the bench drive multi-bit selects and confirm that the lowest set bit wins without the bench tripping an assertion.

// File: rtl/rim_pkg.sv
package rim_pkg;

   // Build of the return-path multiplexer.
   typedef enum logic [0:0] {
      RIM_MUX_FLAT = 1'b0,  // indexed read of a padded table
      RIM_MUX_TREE = 1'b1   // explicit 2:1 tree, one index bit per level
   } rim_mux_e;

endpackage

// File: rtl/rim_encoder.sv
module rim_encoder #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     i_sel,
   output logic [IDX_W-1:0] o_idx,
   output logic             o_any
);

   // Scan from the top down so the lowest set bit is written last.
   always_comb begin
      o_idx = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (i_sel[k]) o_idx = IDX_W'(k);
      end
   end

   assign o_any = |i_sel;

   // Mask of the bits below the chosen one, used by the check.
   logic [N-1:0] below_mask;
   always_comb begin
      for (int k = 0; k < N; k++) begin
         below_mask[k] = (k < int'(o_idx));
      end
   end

   always_comb begin
      if (!$isunknown(i_sel) && o_any) begin
         a_r8_lowest_wins: assert (i_sel[o_idx] && ((i_sel & below_mask) == '0))
            else $error("encoder did not pick the lowest set select bit");
      end
   end

endmodule

// File: rtl/rim_slot.sv
module rim_slot #(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             i_load,
   input  logic [IDX_W-1:0] i_idx,
   input  logic             i_hit,
   output logic [IDX_W-1:0] o_idx,
   output logic             o_busy
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_idx  <= '0;
         o_busy <= 1'b0;
      end else if (i_load) begin
         o_idx  <= i_idx;
         o_busy <= 1'b1;
      end else if (i_hit) begin
         o_busy <= 1'b0;
      end
   end

   a_r1_load_arms: assert property (@(posedge clk) disable iff (!rst_n)
      i_load |=> o_busy);

   a_r5_index_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !i_load |=> $stable(o_idx));

   a_r6_reply_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (o_busy && i_hit && !i_load) |=> !o_busy);

   a_r2_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (!o_busy && !i_load) |=> !o_busy);

endmodule

// File: rtl/rim_mux.sv
module rim_mux #(
   parameter int                N     = 8,
   parameter int                W     = 34,
   parameter int                IDX_W = 3,
   parameter rim_pkg::rim_mux_e STYLE = rim_pkg::RIM_MUX_TREE
) (
   input  logic [N*W-1:0]   i_leaf,
   input  logic [IDX_W-1:0] i_idx,
   output logic [W-1:0]     o_sel
);

   localparam int P = 1 << IDX_W;   // leaves after padding

   if (STYLE == rim_pkg::RIM_MUX_FLAT) begin : g_flat
      logic [W-1:0] tbl [P];
      for (genvar i = 0; i < P; i++) begin : g_ent
         if (i < N) begin : g_real
            assign tbl[i] = i_leaf[i*W +: W];
         end else begin : g_pad
            assign tbl[i] = '0;
         end
      end
      assign o_sel = tbl[i_idx];
   end else begin : g_tree
      // Heap layout: node n has children 2n+1 and 2n+2, leaves at P-1+i.
      logic [W-1:0] node [2*P-1];
      for (genvar i = 0; i < P; i++) begin : g_lf
         if (i < N) begin : g_real
            assign node[P-1+i] = i_leaf[i*W +: W];
         end else begin : g_pad
            assign node[P-1+i] = '0;
         end
      end
      for (genvar n = 0; n < P - 1; n++) begin : g_nd
         localparam int LVL = $clog2(n + 2) - 1;
         assign node[n] = i_idx[IDX_W-1-LVL] ? node[2*n+2] : node[2*n+1];
      end
      assign o_sel = node[0];
   end

endmodule

// File: rtl/resp_index_mux.sv
module resp_index_mux #(
   parameter int                NUM_SLAVES = 8,
   parameter int                DATA_W     = 32,
   parameter rim_pkg::rim_mux_e MUX_STYLE  = rim_pkg::RIM_MUX_TREE,
   parameter bit                STRICT_SEL = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         i_req,
   input  logic [NUM_SLAVES-1:0]        i_sel,
   input  logic [NUM_SLAVES-1:0]        i_slv_ack,
   input  logic [NUM_SLAVES-1:0]        i_slv_err,
   input  logic [NUM_SLAVES*DATA_W-1:0] i_slv_data,
   output logic                         o_ack,
   output logic                         o_err,
   output logic [DATA_W-1:0]            o_data
);

   localparam int IDX_W  = (NUM_SLAVES > 1) ? $clog2(NUM_SLAVES) : 1;
   localparam int LEAF_W = DATA_W + 2;

   if (NUM_SLAVES < 2) begin : g_bad_count
      $error("resp_index_mux needs at least two slaves");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("resp_index_mux needs a data width of at least one bit");
   end

   logic [IDX_W-1:0] enc_idx;
   logic             sel_any;
   logic [IDX_W-1:0] cur_idx;
   logic             busy;
   logic [NUM_SLAVES*LEAF_W-1:0] leaves;
   logic [LEAF_W-1:0] picked;
   logic             sel_ack;
   logic             sel_err;
   logic [DATA_W-1:0] sel_data;
   logic             load;
   logic             hit;

   rim_encoder #(.N(NUM_SLAVES), .IDX_W(IDX_W)) u_enc (
      .i_sel (i_sel),
      .o_idx (enc_idx),
      .o_any (sel_any)
   );

   assign load = i_req & sel_any;

   rim_slot #(.IDX_W(IDX_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .i_load (load),
      .i_idx  (enc_idx),
      .i_hit  (hit),
      .o_idx  (cur_idx),
      .o_busy (busy)
   );

   for (genvar k = 0; k < NUM_SLAVES; k++) begin : g_pack
      assign leaves[k*LEAF_W +: LEAF_W] =
         {i_slv_ack[k], i_slv_err[k], i_slv_data[k*DATA_W +: DATA_W]};
   end

   rim_mux #(
      .N     (NUM_SLAVES),
      .W     (LEAF_W),
      .IDX_W (IDX_W),
      .STYLE (MUX_STYLE)
   ) u_mux (
      .i_leaf (leaves),
      .i_idx  (cur_idx),
      .o_sel  (picked)
   );

   assign {sel_ack, sel_err, sel_data} = picked;
   assign hit    = sel_ack | sel_err;
   assign o_ack  = busy & sel_ack;
   assign o_err  = busy & sel_err;
   assign o_data = sel_data;

   a_r4_ack_from_indexed: assert property (@(posedge clk) disable iff (!rst_n)
      o_ack |-> i_slv_ack[cur_idx]);

   a_r7_err_from_indexed: assert property (@(posedge clk) disable iff (!rst_n)
      o_err |-> i_slv_err[cur_idx]);

   a_r3_data_from_indexed: assert property (@(posedge clk) disable iff (!rst_n)
      o_ack |-> (o_data == i_slv_data[cur_idx*DATA_W +: DATA_W]));

   if (STRICT_SEL) begin : g_strict
      a_r8_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
         i_req |-> $onehot0(i_sel));
   end

endmodule

// File: tb/test_resp_index_mux.sv
module test_resp_index_mux;

   localparam int NS = 6;
   localparam int DW = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req = 1'b0;
   logic [NS-1:0]    sel = '0;
   logic [NS-1:0]    slv_ack = '0;
   logic [NS-1:0]    slv_err = '0;
   logic [NS*DW-1:0] slv_data = '0;
   logic             o_ack;
   logic             o_err;
   logic [DW-1:0]    o_data;

   int n_chk  = 0;
   int n_fail = 0;
   int seq    = 0;

   logic [DW+1:0] exp_q [$];
   string         tag_q [$];

   always #5 clk = ~clk;   // 100 MHz

   resp_index_mux #(
      .NUM_SLAVES (NS),
      .DATA_W     (DW),
      .MUX_STYLE  (rim_pkg::RIM_MUX_TREE),
      .STRICT_SEL (1'b0)
   ) i_resp_index_mux (
      .clk        (clk),
      .rst_n      (rst_n),
      .i_req      (req),
      .i_sel      (sel),
      .i_slv_ack  (slv_ack),
      .i_slv_err  (slv_err),
      .i_slv_data (slv_data),
      .o_ack      (o_ack),
      .o_err      (o_err),
      .o_data     (o_data)
   );

   task automatic chk(string tag, logic [DW+1:0] act, logic [DW+1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic expect_idle(string tag);
      #3;
      chk(tag, {o_ack, o_err, {DW{1'b0}}}, '0);
   endtask

   function automatic logic [NS-1:0] bit_of(int k);
      return NS'(1) << k;
   endfunction

   // Monitor: every reply seen at the outputs must match the queue head.
   initial begin
      forever begin
         @(negedge clk);
         #3;
         if (rst_n) begin
            if (o_ack || o_err) begin
               if (exp_q.size() == 0) begin
                  n_chk++; n_fail++;
                  $display("FAIL R4: unexpected reply ack=%b err=%b data=%h, expected none",
                           o_ack, o_err, o_data);
               end else begin
                  chk(tag_q.pop_front(), {o_ack, o_err, o_data}, exp_q.pop_front());
               end
            end else if (exp_q.size() != 0) begin
               n_chk++; n_fail++;
               $display("FAIL %s: reply missing, got %h expected %h",
                        tag_q.pop_front(), {o_ack, o_err, o_data}, exp_q.pop_front());
            end
         end
      end
   end

   // Driver: one request, stray traffic while waiting, reply, then a stale reply.
   task automatic txn(string tag, logic [NS-1:0] s, int tgt, int lat,
                      logic [NS-1:0] stray, bit use_err);
      logic [DW-1:0] d;
      @(negedge clk); req = 1'b1; sel = s;
      @(negedge clk); req = 1'b0; sel = '0;
      for (int i = 1; i < lat; i++) begin
         slv_ack = stray & ~bit_of(tgt);
         slv_err = stray & ~bit_of(tgt);
         expect_idle(tag);                 // R5: still waiting, strays dropped
         @(negedge clk);
      end
      seq++;
      d = 16'hC3A5 ^ DW'(seq * 16'h0137);
      slv_data[tgt*DW +: DW] = d;
      slv_ack = stray & ~bit_of(tgt);      // R4: strays also in the reply cycle
      slv_err = '0;
      if (use_err) slv_err[tgt] = 1'b1; else slv_ack[tgt] = 1'b1;
      exp_q.push_back({~use_err, use_err, d});
      tag_q.push_back(tag);
      @(negedge clk);
      slv_ack = bit_of(tgt);               // R6: stale reply must be dropped
      slv_err = bit_of(tgt);
      expect_idle("R6");
      @(negedge clk);
      slv_ack = '0; slv_err = '0;
   endtask

   initial begin
      for (int k = 0; k < NS; k++) slv_data[k*DW +: DW] = 16'h1000 + DW'(k * 16'h0111);
      slv_ack = '1; slv_err = '1;
      repeat (3) @(negedge clk);
      #3;
      chk("R9", {o_ack, o_err, {DW{1'b0}}}, '0);          // quiet in reset
      @(negedge clk); rst_n = 1'b1;
      expect_idle("R2");                                   // no request: replies dropped
      chk("R9", {2'b00, o_data}, {2'b00, 16'h1000});       // index 0 after reset
      @(negedge clk); slv_ack = '0; slv_err = '0;

      txn("R1", bit_of(3), 3, 1, '0, 1'b0);
      txn("R3", bit_of(0), 0, 1, 6'b000110, 1'b0);
      txn("R5", bit_of(5), 5, 4, 6'b011111, 1'b0);
      txn("R7", bit_of(0), 0, 2, 6'b100010, 1'b1);
      txn("R8", 6'b101100, 2, 2, 6'b101000, 1'b0);         // lowest set bit is slave 2

      // R2: empty select stores nothing; index stays at slave 2
      @(negedge clk); req = 1'b1; sel = '0;
      @(negedge clk); req = 1'b0; slv_ack = '1; slv_err = '1;
      expect_idle("R2");
      chk("R2", {2'b00, o_data}, {2'b00, slv_data[2*DW +: DW]});
      @(negedge clk); slv_ack = '0; slv_err = '0;

      // R10: reply from slave 1 in the same cycle as a request to slave 4
      @(negedge clk); req = 1'b1; sel = bit_of(1);
      @(negedge clk); sel = bit_of(4);
      slv_data[1*DW +: DW] = 16'h5A11; slv_ack = bit_of(1);
      exp_q.push_back({2'b10, 16'h5A11}); tag_q.push_back("R10");
      @(negedge clk); req = 1'b0; sel = '0; slv_ack = '0;
      expect_idle("R10");
      @(negedge clk);
      slv_data[4*DW +: DW] = 16'h4E44; slv_ack = bit_of(4) | bit_of(1);
      exp_q.push_back({2'b10, 16'h4E44}); tag_q.push_back("R10");
      @(negedge clk); slv_ack = bit_of(4);
      expect_idle("R6");
      @(negedge clk); slv_ack = '0;

      txn("R1", bit_of(1), 1, 3, 6'b111101, 1'b1);
      txn("R3", 6'b110000, 4, 2, 6'b100001, 1'b0);

      repeat (3) @(negedge clk);
      chk("R3", DW'(exp_q.size()), '0);                     // all replies seen
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule